// File: doc/BRIEF.md
# Counter Read-Modify-Write Engine with Flush Hold-Off

This block keeps per-flow statistics in a memory of 72-bit words. Each word holds a packet count in the upper 32 bits (71:40) and a byte count in the lower 40 bits (39:0). Two request streams share one memory channel. Increment requests carry packet and byte deltas and make the engine read the word, add the deltas and write the sum back. Flush requests come from the host once per accounting period. A flush reads the word, returns the pair on a response port so software can move it into a lifetime store, and writes zero back so that counting restarts.

The memory port is a plain synchronous RAM with a read latency of `RD_LAT` cycles. Every write-back issues in the cycle its read data returns. A table of in-flight addresses makes sure that no two operations on the same counter overlap. Increments win arbitration. A flush still goes through in a cycle when the waiting increment is stalled by an address hazard. A flush marked as the last of its burst starts a hold-off. While that flush is in flight, and for `HOLD_CYC` clocks after its write-back, no further flush is accepted.

Top module: `ctr_rmw_engine`

## Requirements
- R1: An accepted increment reads the word at its address and writes back the packet field plus `inc_pkt` in bits 71:40 and the byte field plus `inc_bytes` in bits 39:0.
- R2: Each field stops at all ones instead of wrapping when the sum overflows its width.
- R3: A flush accepted in cycle c drives `rsp_valid` in cycle c+RD_LAT with the stored pair and address, and writes zero to that word in the same cycle.
- R4: A request whose address matches an operation still in flight waits. A second access to one address is accepted RD_LAT+1 cycles after the first, and a read never targets the address being written in the same cycle.
- R5: Increments to distinct addresses are accepted on consecutive cycles.
- R6: When an increment and a flush are both eligible, the increment is accepted and the flush follows one cycle later.
- R7: When the pending increment is stalled by a hazard, an eligible flush is accepted in that cycle.
- R8: After a flush with `flush_last` set is accepted in cycle c, no flush is accepted before cycle c+RD_LAT+HOLD_CYC+1, and a waiting flush is accepted in exactly that cycle.
- R9: After reset both request ports are ready, and there is no response, no memory read and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_valid | input | 1 | Increment request present |
| inc_ready | output | 1 | Increment accepted this cycle when valid |
| inc_addr | input | ADDR_W | Counter index to increment |
| inc_pkt | input | DPKT_W | Packet delta |
| inc_bytes | input | DBYTE_W | Byte delta |
| flush_valid | input | 1 | Flush request present |
| flush_last | input | 1 | Marks the final flush of a periodic burst |
| flush_ready | output | 1 | Flush accepted this cycle when valid |
| flush_addr | input | ADDR_W | Counter index to flush |
| rsp_valid | output | 1 | Flushed counter pair present |
| rsp_addr | output | ADDR_W | Index of the flushed counter |
| rsp_pkt | output | PKT_W | Flushed packet count |
| rsp_bytes | output | BYTE_W | Flushed byte count |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | PKT_W+BYTE_W | Read data, RD_LAT cycles after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | PKT_W+BYTE_W | Memory write data |

## Verification
The bench drives increments to distinct addresses back to back. This shows full throughput and shows that each sum lands in the right field. Repeated increments to one address show the hazard stall and its exact length, and an increment near full scale tells saturation apart from wraparound. Increments and flushes offered together separate strict increment priority from the hazard bypass. A flush burst that ends with a last flush, followed at once by a waiting flush, measures the hold-off window. Flushing the same counter again and then incrementing it confirms the zero write-back.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic {
    OP_INC   = 1'b0,
    OP_FLUSH = 1'b1
  } op_e;
endpackage

// File: rtl/ctr_sat_add.sv
module ctr_sat_add #(
  parameter int PKT_W   = 32,
  parameter int BYTE_W  = 40,
  parameter int DPKT_W  = 16,
  parameter int DBYTE_W = 24
) (
  input  logic [PKT_W-1:0]   old_pkt,
  input  logic [BYTE_W-1:0]  old_bytes,
  input  logic [DPKT_W-1:0]  d_pkt,
  input  logic [DBYTE_W-1:0] d_bytes,
  output logic [PKT_W-1:0]   new_pkt,
  output logic [BYTE_W-1:0]  new_bytes
);
  localparam int PW1 = PKT_W + 1;
  localparam int BW1 = BYTE_W + 1;

  logic [PKT_W:0]  sum_pkt;
  logic [BYTE_W:0] sum_bytes;

  always_comb begin
    sum_pkt   = {1'b0, old_pkt} + PW1'(d_pkt);
    sum_bytes = {1'b0, old_bytes} + BW1'(d_bytes);
    new_pkt   = sum_pkt[PKT_W]    ? '1 : sum_pkt[PKT_W-1:0];
    new_bytes = sum_bytes[BYTE_W] ? '1 : sum_bytes[BYTE_W-1:0];
  end

  // R2
  always_comb begin
    sat_nowrap_chk: assert ((new_pkt >= old_pkt) && (new_bytes >= old_bytes));
  end
endmodule

// File: rtl/ctr_inflight.sv
module ctr_inflight
  import ctr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DPKT_W  = 16,
  parameter int DBYTE_W = 24,
  parameter int RD_LAT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  op_e                push_op,
  input  logic               push_last,
  input  logic [ADDR_W-1:0]  push_addr,
  input  logic [DPKT_W-1:0]  push_dpkt,
  input  logic [DBYTE_W-1:0] push_dbytes,
  input  logic [ADDR_W-1:0]  probe_a,
  input  logic [ADDR_W-1:0]  probe_b,
  output logic               hit_a,
  output logic               hit_b,
  output logic               tail_valid,
  output op_e                tail_op,
  output logic               tail_last,
  output logic [ADDR_W-1:0]  tail_addr,
  output logic [DPKT_W-1:0]  tail_dpkt,
  output logic [DBYTE_W-1:0] tail_dbytes
);
  logic [RD_LAT-1:0]              v_q, v_d;
  logic [RD_LAT-1:0]              op_q, op_d;
  logic [RD_LAT-1:0]              last_q, last_d;
  logic [RD_LAT-1:0][ADDR_W-1:0]  a_q, a_d;
  logic [RD_LAT-1:0][DPKT_W-1:0]  dp_q, dp_d;
  logic [RD_LAT-1:0][DBYTE_W-1:0] db_q, db_d;
  logic                           shift_en;

  always_comb begin
    v_d[0]    = push;
    op_d[0]   = push_op;
    last_d[0] = push_last;
    a_d[0]    = push_addr;
    dp_d[0]   = push_dpkt;
    db_d[0]   = push_dbytes;
    for (int k = 1; k < RD_LAT; k++) begin
      v_d[k]    = v_q[k-1];
      op_d[k]   = op_q[k-1];
      last_d[k] = last_q[k-1];
      a_d[k]    = a_q[k-1];
      dp_d[k]   = dp_q[k-1];
      db_d[k]   = db_q[k-1];
    end
    shift_en = push | (|v_q);
  end

  always_comb begin
    hit_a = 1'b0;
    hit_b = 1'b0;
    for (int k = 0; k < RD_LAT; k++) begin
      if (v_q[k] && (a_q[k] == probe_a)) hit_a = 1'b1;
      if (v_q[k] && (a_q[k] == probe_b)) hit_b = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      op_q   <= op_d;
      last_q <= last_d;
      a_q    <= a_d;
      dp_q   <= dp_d;
      db_q   <= db_d;
    end
  end

  assign tail_valid  = v_q[RD_LAT-1];
  assign tail_op     = op_e'(op_q[RD_LAT-1]);
  assign tail_last   = last_q[RD_LAT-1];
  assign tail_addr   = a_q[RD_LAT-1];
  assign tail_dpkt   = dp_q[RD_LAT-1];
  assign tail_dbytes = db_q[RD_LAT-1];

  // R4
  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < RD_LAT; i++)
        for (int j = i + 1; j < RD_LAT; j++)
          if (v_q[i] && v_q[j])
            inflight_uniq_chk: assert (a_q[i] != a_q[j]);
    end
  end
endmodule

// File: rtl/ctr_gap.sv
module ctr_gap #(
  parameter int HOLD_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic done,
  output logic block
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic             closing_q, closing_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    closing_d = closing_q;
    if (arm)  closing_d = 1'b1;
    if (done) closing_d = 1'b0;
    cnt_d = cnt_q;
    if (done)              cnt_d = CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      closing_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      closing_q <= closing_d;
      cnt_q     <= cnt_d;
    end
  end

  assign block = closing_q | (cnt_q != '0);

  // R8
  gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> block);
  // R8
  gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ctr_rmw_engine.sv
module ctr_rmw_engine
  import ctr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int PKT_W    = 32,
  parameter int BYTE_W   = 40,
  parameter int DPKT_W   = 16,
  parameter int DBYTE_W  = 24,
  parameter int RD_LAT   = 2,
  parameter int HOLD_CYC = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc_valid,
  output logic                      inc_ready,
  input  logic [ADDR_W-1:0]         inc_addr,
  input  logic [DPKT_W-1:0]         inc_pkt,
  input  logic [DBYTE_W-1:0]        inc_bytes,
  input  logic                      flush_valid,
  input  logic                      flush_last,
  output logic                      flush_ready,
  input  logic [ADDR_W-1:0]         flush_addr,
  output logic                      rsp_valid,
  output logic [ADDR_W-1:0]         rsp_addr,
  output logic [PKT_W-1:0]          rsp_pkt,
  output logic [BYTE_W-1:0]         rsp_bytes,
  output logic                      mem_rd_en,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic [PKT_W+BYTE_W-1:0]   mem_rd_data,
  output logic                      mem_wr_en,
  output logic [ADDR_W-1:0]         mem_wr_addr,
  output logic [PKT_W+BYTE_W-1:0]   mem_wr_data
);
  localparam int WORD_W = PKT_W + BYTE_W;

  logic               hit_inc, hit_fl, gap_block;
  logic               inc_ok, flush_ok, inc_fire, flush_fire, push;
  op_e                push_op;
  logic [ADDR_W-1:0]  push_addr;
  logic               tail_valid, tail_last;
  op_e                tail_op;
  logic [ADDR_W-1:0]  tail_addr;
  logic [DPKT_W-1:0]  tail_dpkt;
  logic [DBYTE_W-1:0] tail_dbytes;
  logic [PKT_W-1:0]   sum_pkt;
  logic [BYTE_W-1:0]  sum_bytes;
  logic               tail_flush;

  // arbitration: increments first, flush fills the slot an increment leaves
  always_comb begin
    inc_ok      = !hit_inc;
    flush_ok    = !hit_fl && !gap_block;
    inc_ready   = inc_ok;
    flush_ready = flush_ok && !(inc_valid && inc_ok);
    inc_fire    = inc_valid && inc_ready;
    flush_fire  = flush_valid && flush_ready;
    push        = inc_fire || flush_fire;
    push_op     = flush_fire ? OP_FLUSH : OP_INC;
    push_addr   = flush_fire ? flush_addr : inc_addr;
  end

  ctr_inflight #(
    .ADDR_W (ADDR_W), .DPKT_W (DPKT_W), .DBYTE_W (DBYTE_W), .RD_LAT (RD_LAT)
  ) u_inflight (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .push_op     (push_op),
    .push_last   (flush_fire && flush_last),
    .push_addr   (push_addr),
    .push_dpkt   (flush_fire ? '0 : inc_pkt),
    .push_dbytes (flush_fire ? '0 : inc_bytes),
    .probe_a     (inc_addr),
    .probe_b     (flush_addr),
    .hit_a       (hit_inc),
    .hit_b       (hit_fl),
    .tail_valid  (tail_valid),
    .tail_op     (tail_op),
    .tail_last   (tail_last),
    .tail_addr   (tail_addr),
    .tail_dpkt   (tail_dpkt),
    .tail_dbytes (tail_dbytes)
  );

  ctr_sat_add #(
    .PKT_W (PKT_W), .BYTE_W (BYTE_W), .DPKT_W (DPKT_W), .DBYTE_W (DBYTE_W)
  ) u_add (
    .old_pkt   (mem_rd_data[WORD_W-1:BYTE_W]),
    .old_bytes (mem_rd_data[BYTE_W-1:0]),
    .d_pkt     (tail_dpkt),
    .d_bytes   (tail_dbytes),
    .new_pkt   (sum_pkt),
    .new_bytes (sum_bytes)
  );

  ctr_gap #(.HOLD_CYC (HOLD_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (flush_fire && flush_last),
    .done  (tail_valid && (tail_op == OP_FLUSH) && tail_last),
    .block (gap_block)
  );

  always_comb begin
    tail_flush  = tail_valid && (tail_op == OP_FLUSH);
    mem_rd_en   = push;
    mem_rd_addr = push_addr;
    mem_wr_en   = tail_valid;
    mem_wr_addr = tail_addr;
    mem_wr_data = tail_flush ? '0 : {sum_pkt, sum_bytes};
    rsp_valid   = tail_flush;
    rsp_addr    = tail_addr;
    rsp_pkt     = mem_rd_data[WORD_W-1:BYTE_W];
    rsp_bytes   = mem_rd_data[BYTE_W-1:0];
  end

  // R3
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_wr_en && (mem_wr_addr == rsp_addr) && (mem_wr_data == '0)));
  // R4
  rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_wr_en) |-> (mem_rd_addr != mem_wr_addr));
  // R8
  gap_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && tail_last) |=> !flush_ready);
endmodule

// File: tb/ctr_rmw_engine_bench.sv
module ctr_rmw_engine_bench;
  localparam int ADDR_W = 4, PKT_W = 32, BYTE_W = 40, DPKT_W = 16, DBYTE_W = 24;
  localparam int RD_LAT = 2, HOLD_CYC = 5;
  localparam int WORD_W = PKT_W + BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk, rst_n;
  logic inc_valid, inc_ready, flush_valid, flush_last, flush_ready;
  logic [ADDR_W-1:0] inc_addr, flush_addr, rsp_addr, mem_rd_addr, mem_wr_addr;
  logic [DPKT_W-1:0] inc_pkt;
  logic [DBYTE_W-1:0] inc_bytes;
  logic rsp_valid, mem_rd_en, mem_wr_en;
  logic [PKT_W-1:0] rsp_pkt;
  logic [BYTE_W-1:0] rsp_bytes;
  logic [WORD_W-1:0] mem_rd_data, mem_wr_data;

  ctr_rmw_engine #(
    .ADDR_W(ADDR_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W), .DPKT_W(DPKT_W),
    .DBYTE_W(DBYTE_W), .RD_LAT(RD_LAT), .HOLD_CYC(HOLD_CYC)
  ) u_ctr_rmw_engine (
    .clk(clk), .rst_n(rst_n),
    .inc_valid(inc_valid), .inc_ready(inc_ready), .inc_addr(inc_addr),
    .inc_pkt(inc_pkt), .inc_bytes(inc_bytes),
    .flush_valid(flush_valid), .flush_last(flush_last), .flush_ready(flush_ready),
    .flush_addr(flush_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_pkt(rsp_pkt), .rsp_bytes(rsp_bytes),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  int cyc;
  always @(posedge clk) cyc <= cyc + 1;

  // synchronous RAM with RD_LAT read latency
  logic [WORD_W-1:0] ram [DEPTH];
  logic [WORD_W-1:0] rdp [RD_LAT];
  always @(posedge clk) begin
    if (mem_wr_en) ram[mem_wr_addr] <= mem_wr_data;
    rdp[0] <= ram[mem_rd_addr];
    for (int k = 1; k < RD_LAT; k++) rdp[k] <= rdp[k-1];
  end
  assign mem_rd_data = rdp[RD_LAT-1];

  // reference counters
  logic [PKT_W-1:0]  m_pkt [DEPTH];
  logic [BYTE_W-1:0] m_byt [DEPTH];

  typedef struct {
    int                a;
    logic [PKT_W-1:0]  p;
    logic [BYTE_W-1:0] b;
    int                cy;
  } exp_t;
  exp_t expq[$];

  int n_chk, n_err;

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] sat(input logic [63:0] a, input logic [63:0] d, input int w);
    logic [63:0] mx, s;
    mx = (64'd1 << w) - 1;
    s  = a + d;
    return (s > mx) ? mx : s;
  endfunction

  // called at a negedge, returns at a negedge
  task automatic send_inc(input int a, input int p, input int b, output int acc);
    bit f;
    inc_valid = 1'b1; inc_addr = ADDR_W'(a); inc_pkt = DPKT_W'(p); inc_bytes = DBYTE_W'(b);
    forever begin
      #1ns; f = inc_ready;
      @(posedge clk);
      if (f) break;
      @(negedge clk);
    end
    acc = cyc;
    m_pkt[a] = PKT_W'(sat(64'(m_pkt[a]), 64'(p), PKT_W));
    m_byt[a] = BYTE_W'(sat(64'(m_byt[a]), 64'(b), BYTE_W));
    @(negedge clk);
    inc_valid = 1'b0;
  endtask

  task automatic send_flush(input int a, input bit last, output int acc);
    bit f;
    exp_t e;
    flush_valid = 1'b1; flush_addr = ADDR_W'(a); flush_last = last;
    forever begin
      #1ns; f = flush_ready;
      @(posedge clk);
      if (f) break;
      @(negedge clk);
    end
    acc = cyc;
    e.a = a; e.p = m_pkt[a]; e.b = m_byt[a]; e.cy = acc + RD_LAT;
    expq.push_back(e);
    m_pkt[a] = '0; m_byt[a] = '0;
    @(negedge clk);
    flush_valid = 1'b0; flush_last = 1'b0;
  endtask

  // monitor: flushed pairs, R1 R2 R3
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected response", 64'(rsp_addr), 64'hffff);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rsp_addr == ADDR_W'(e.a), "R3 rsp_addr", 64'(rsp_addr), 64'(e.a));
        check(rsp_pkt == e.p, "R1 R2 rsp_pkt", 64'(rsp_pkt), 64'(e.p));
        check(rsp_bytes == e.b, "R1 R2 rsp_bytes", 64'(rsp_bytes), 64'(e.b));
        check(cyc == e.cy, "R3 rsp cycle", 64'(cyc), 64'(e.cy));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c0, c1, c2, c3;
    n_chk = 0; n_err = 0; cyc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = '0; m_pkt[i] = '0; m_byt[i] = '0;
    end
    for (int k = 0; k < RD_LAT; k++) rdp[k] = '0;
    ram[5]   = {{PKT_W{1'b1}} - PKT_W'(2), {BYTE_W{1'b1}} - BYTE_W'(10)};
    m_pkt[5] = {PKT_W{1'b1}} - PKT_W'(2);
    m_byt[5] = {BYTE_W{1'b1}} - BYTE_W'(10);
    inc_valid = 0; flush_valid = 0; flush_last = 0;
    inc_addr = '0; flush_addr = '0; inc_pkt = '0; inc_bytes = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(inc_ready == 1'b1, "R9 inc_ready", 64'(inc_ready), 64'd1);
    check(flush_ready == 1'b1, "R9 flush_ready", 64'(flush_ready), 64'd1);
    check(rsp_valid == 1'b0, "R9 rsp_valid", 64'(rsp_valid), 64'd0);
    check(mem_wr_en == 1'b0 && mem_rd_en == 1'b0, "R9 mem idle",
          64'({mem_wr_en, mem_rd_en}), 64'd0);

    // R5 distinct addresses back to back, R1 values
    send_inc(1, 3, 100, c0);
    send_inc(2, 7, 1500, c1);
    send_inc(3, 1, 64, c2);
    check(c1 == c0 + 1, "R5 second accept", 64'(c1 - c0), 64'd1);
    check(c2 == c1 + 1, "R5 third accept", 64'(c2 - c1), 64'd1);

    // R4 same address stalls
    send_inc(1, 2, 40, c0);
    send_inc(1, 5, 60, c1);
    check(c1 == c0 + RD_LAT + 1, "R4 hazard gap", 64'(c1 - c0), 64'(RD_LAT + 1));

    // R2 saturation
    send_inc(5, 10, 100, c0);
    repeat (RD_LAT + 1) @(negedge clk);
    send_flush(5, 1'b0, c0);
    repeat (RD_LAT + 1) @(negedge clk);

    // R6 increment wins
    fork
      send_inc(7, 4, 44, c0);
      send_flush(8, 1'b0, c1);
    join
    check(c1 == c0 + 1, "R6 flush after inc", 64'(c1 - c0), 64'd1);
    repeat (RD_LAT + 1) @(negedge clk);

    // R7 flush takes slot of a stalled increment
    send_inc(9, 1, 10, c0);
    fork
      send_inc(9, 1, 10, c2);
      send_flush(10, 1'b0, c1);
    join
    check(c1 == c0 + 1, "R7 flush bypass", 64'(c1 - c0), 64'd1);
    check(c2 == c0 + RD_LAT + 1, "R7 stalled inc", 64'(c2 - c0), 64'(RD_LAT + 1));
    repeat (RD_LAT + 1) @(negedge clk);

    // R1 R3 R8 flush burst with hold-off
    send_flush(2, 1'b0, c0);
    send_flush(9, 1'b0, c0);
    send_flush(3, 1'b1, c0);
    send_flush(1, 1'b0, c1);
    check(c1 == c0 + RD_LAT + HOLD_CYC + 1, "R8 hold-off gap",
          64'(c1 - c0), 64'(RD_LAT + HOLD_CYC + 1));
    repeat (RD_LAT + 1) @(negedge clk);

    // R3 zero write-back: recount from zero
    send_flush(2, 1'b0, c3);
    send_inc(1, 6, 77, c3);
    repeat (RD_LAT + 1) @(negedge clk);
    send_flush(1, 1'b0, c3);
    repeat (RD_LAT + 4) @(negedge clk);
    check(expq.size() == 0, "R3 responses drained", 64'(expq.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule